// File: doc/BRIEF.md
# Prioritized Two-Output Interrupt Controller

The block gathers up to 64 peripheral request lines into pending flags, holds a per-source enable and a 3-bit priority, and from those drives two active-low processor request outputs. A source whose priority value is 0 or 1 belongs to the fast output (`fiq_n`). Values 2 to 7 send it to the normal output (`irq_n`). A larger value means lower urgency. For each output the block picks one winner among the sources that are pending, enabled and routed there. It publishes that winner as an entry word: a programmable base plus four times the winner index plus one. The word reads as zero when that path has nothing to serve.

Software reaches the block over a plain 32-bit register bus with an 8-bit byte address. Writes take effect on the clock edge and reads return combinationally. Sources are split into 32-bit banks: source n lives at bit n mod 32 of bank n div 32. Edge sources are captured on a rising edge. Software clears them by writing ones to the pending view of their path. A single source, chosen by the `LEVEL_IDX` parameter, is level-sensitive instead. Its flag simply tracks the input one cycle later.

Top module: `prio_intc`

## Requirements
- R1: An edge source n sets its pending flag at the first clock edge where its input is high and was low at the previous edge. Pending flags of fast-routed sources read at 0x00 (bank 0) and 0x04 (bank 1); those of normal-routed sources read at 0x08 and 0x0C. Bit n mod 32 of the bank word belongs to source n. A flag is set regardless of its enable.
- R2: Writing a word to a pending view clears every flag whose bit is 1 in the word and whose source is routed to that view's path. Zero bits have no effect, and so do one bits for sources on the other path.
- R3: When a rising edge and a clearing write hit the same source in the same cycle, the flag stays set.
- R4: Enable words sit at 0x18 (sources 0 to 31) and 0x1C (sources 32 to 63), 1 meaning enabled, and read back as written. All enables are 0 after reset. A pending source that is disabled takes no part in arbitration and drives no output, and this applies from the cycle after the disabling write.
- R5: Priority words sit at 0x30 + 4*(n div 8). Source n occupies nibble n mod 8, bits [4k+2:4k] with k = n mod 8. Bit 4k+3 is ignored on write and reads 0. Every priority resets to 7.
- R6: A priority of 0 or 1 routes a source to the fast path and `fiq_n`. A priority of 2 to 7 routes it to the normal path and `irq_n`.
- R7: On each path the winner is the pending, enabled source with the smallest priority value. A tie goes to the smaller source index.
- R8: The read-only entry words are at 0x10 (fast path) and 0x14 (normal path). Each reads base + 4*(winner index + 1), or 0 when the path has no pending enabled source.
- R9: The base word at 0x24 is read/write and resets to 0. The control word at 0x20 keeps bit 0 (read/write, reset 0; other bits read 0). The block runs in the mode that control value 0 selects, in which disables act at once and the normal entry covers every pending enabled source.
- R10: The source at index `LEVEL_IDX` has a pending flag equal to its input at the previous clock edge. Clearing writes do not affect it.
- R11: `fiq_n` and `irq_n` are registered, are high in reset, and go low one clock edge after the pending, enable and priority state has a pending enabled source on their path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_in | input | 64 | Peripheral request lines |
| fiq_n | output | 1 | Fast path request, active low |
| irq_n | output | 1 | Normal path request, active low |

## Verification
The bench builds the block with 64 sources and moves the level-sensitive source to index 45. That puts it in the upper bank and inside priority word 5, next to edge sources. A random priority write can therefore carry it between paths, and bank-1 clears that also cover edge neighbours exercise it. Random enables, priority words and clears are mixed with sparse random input toggles. Under that load both arbiters see many simultaneous requesters and equal-priority ties. Directed cases cover edge-versus-clear collisions and routing with reserved nibble bits.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam int PRIO_W = 3;
  localparam int BANK_W = 32;
  localparam int SRC_PER_PREG = 8;

  localparam logic [ADDR_W-1:0] ADR_FAST_PEND  = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_NORM_PEND  = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_FAST_ENTRY = 8'h10;
  localparam logic [ADDR_W-1:0] ADR_NORM_ENTRY = 8'h14;
  localparam logic [ADDR_W-1:0] ADR_ENABLE     = 8'h18;
  localparam logic [ADDR_W-1:0] ADR_CTRL       = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_BASE       = 8'h24;
  localparam logic [ADDR_W-1:0] ADR_PRIO       = 8'h30;

  localparam logic [PRIO_W-1:0] PRIO_RESET = 3'd7;
  localparam logic [PRIO_W-1:0] FAST_LIMIT = 3'd1;

  // a priority at or below the limit selects the fast output
  function automatic logic goes_fast(input logic [PRIO_W-1:0] p);
    return p <= FAST_LIMIT;
  endfunction

  // entry word: base + 4*(index+1), zero when the path is idle
  function automatic logic [DATA_W-1:0] entry_word(input logic [DATA_W-1:0] base,
                                                   input int idx,
                                                   input logic valid);
    logic [DATA_W-1:0] off;
    off = DATA_W'((idx + 1) * 4);
    return valid ? base + off : '0;
  endfunction

  // byte address of the n-th word in a block starting at first
  function automatic logic [ADDR_W-1:0] word_addr(input logic [ADDR_W-1:0] first, input int n);
    return first + ADDR_W'(4 * n);
  endfunction
endpackage

// File: rtl/intc_regs.sv
`timescale 1ns/1ps
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int NBANK = NSRC / BANK_W,
  localparam int NPREG = NSRC / SRC_PER_PREG
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 we,
  input  logic [DATA_W-1:0]    wdata,
  output logic [NSRC-1:0]      en_q,
  output logic [NSRC*PRIO_W-1:0] prio_q,
  output logic                 ctrl_q,
  output logic [DATA_W-1:0]    base_q,
  output logic [NSRC-1:0]      clr_fast_wr,
  output logic [NSRC-1:0]      clr_norm_wr
);
  logic wr_base, wr_ctrl, wr_any_en;
  logic [NBANK-1:0] wr_en_bank;

  assign wr_base = we && (addr == ADR_BASE);
  assign wr_ctrl = we && (addr == ADR_CTRL);
  assign wr_any_en = |wr_en_bank;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [BANK_W-1:0] en_bank_q;
    assign wr_en_bank[b] = we && (addr == word_addr(ADR_ENABLE, b));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_bank_q <= '0;
      else if (wr_en_bank[b]) en_bank_q <= wdata;
    end
    assign en_q[b*BANK_W +: BANK_W] = en_bank_q;
    assign clr_fast_wr[b*BANK_W +: BANK_W] =
      (we && addr == word_addr(ADR_FAST_PEND, b)) ? wdata : '0;
    assign clr_norm_wr[b*BANK_W +: BANK_W] =
      (we && addr == word_addr(ADR_NORM_PEND, b)) ? wdata : '0;
  end

  for (genvar r = 0; r < NPREG; r++) begin : g_preg
    logic wr_this;
    assign wr_this = we && (addr == word_addr(ADR_PRIO, r));
    for (genvar k = 0; k < SRC_PER_PREG; k++) begin : g_nib
      logic [PRIO_W-1:0] p_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= PRIO_RESET;
        else if (wr_this) p_q <= wdata[4*k +: PRIO_W];
      end
      assign prio_q[(r*SRC_PER_PREG+k)*PRIO_W +: PRIO_W] = p_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ctrl_q <= 1'b0;
    end else begin
      if (wr_base) base_q <= wdata;
      if (wr_ctrl) ctrl_q <= wdata[0];
    end
  end

  // R9: base only moves on a write to its own address
  p_base_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_base |=> $stable(base_q));
  // R4: enables only move on a write to an enable word
  p_en_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any_en |=> $stable(en_q));
  // R2: only one pending view can be written per cycle
  p_one_clear_view_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !((|clr_fast_wr) && (|clr_norm_wr)));
endmodule

// File: rtl/intc_pend.sv
`timescale 1ns/1ps
module intc_pend #(
  parameter int NSRC = 64,
  parameter int LEVEL_IDX = 33
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic [NSRC-1:0] clr,
  output logic [NSRC-1:0] pend_q,
  output logic [NSRC-1:0] rise
);
  localparam logic [NSRC-1:0] EDGE_MASK = ~(NSRC'(1) << LEVEL_IDX);

  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else prev_q <= src;
  end

  assign rise = src & ~prev_q;

  for (genvar n = 0; n < NSRC; n++) begin : g_src
    logic b_q;
    if (n == LEVEL_IDX) begin : g_level
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= 1'b0;
        else b_q <= src[n];
      end
      // R10: the level flag follows the input and ignores clears
      p_level_follow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(clr[n]) |-> (pend_q[n] == $past(src[n])));
    end else begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) b_q <= 1'b0;
        else b_q <= (b_q & ~clr[n]) | rise[n];
      end
    end
    assign pend_q[n] = b_q;
  end

  // R1: an edge flag can only turn on after a rising edge
  p_set_by_edge_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & ~$past(pend_q) & ~$past(rise) & EDGE_MASK) == '0));
  // R2: a clear without a coinciding edge drops the flag
  p_clear_drops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & $past(clr & ~rise) & EDGE_MASK) == '0));
  // R3: an edge always leaves its flag set, clear or not
  p_edge_beats_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ((pend_q & $past(rise) & EDGE_MASK) == ($past(rise) & EDGE_MASK)));
endmodule

// File: rtl/intc_arb.sv
`timescale 1ns/1ps
module intc_arb
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  localparam int IW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]        req,
  input  logic [NSRC*PRIO_W-1:0] prio,
  output logic                   valid,
  output logic [IW-1:0]          win
);
  // scan from the top so that a later, lower index takes ties
  always_comb begin
    logic [PRIO_W-1:0] best;
    valid = 1'b0;
    win   = '0;
    best  = '1;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (req[n] && (!valid || prio[n*PRIO_W +: PRIO_W] <= best)) begin
        valid = 1'b1;
        best  = prio[n*PRIO_W +: PRIO_W];
        win   = IW'(n);
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
`timescale 1ns/1ps
module prio_intc
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int LEVEL_IDX = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NSRC-1:0]   src_in,
  output logic              fiq_n,
  output logic              irq_n
);
  localparam int NBANK = NSRC / BANK_W;
  localparam int NPREG = NSRC / SRC_PER_PREG;
  localparam int IW = $clog2(NSRC);

  logic [NSRC-1:0] en_q, pend_q, rise, fast_route;
  logic [NSRC-1:0] clr_fast_wr, clr_norm_wr, clr;
  logic [NSRC*PRIO_W-1:0] prio_q;
  logic ctrl_q;
  logic [DATA_W-1:0] base_q, fast_entry, norm_entry;
  logic [NSRC-1:0] req_fast, req_norm;
  logic fast_valid, norm_valid;
  logic [IW-1:0] fast_win, norm_win;
  logic fiq_q, irq_q;

  intc_regs #(.NSRC(NSRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .we(bus_we), .wdata(bus_wdata),
    .en_q(en_q), .prio_q(prio_q), .ctrl_q(ctrl_q), .base_q(base_q),
    .clr_fast_wr(clr_fast_wr), .clr_norm_wr(clr_norm_wr)
  );

  for (genvar n = 0; n < NSRC; n++) begin : g_route
    assign fast_route[n] = goes_fast(prio_q[n*PRIO_W +: PRIO_W]);
  end

  // a clear only reaches sources routed to the view that was written
  assign clr = (clr_fast_wr & fast_route) | (clr_norm_wr & ~fast_route);

  intc_pend #(.NSRC(NSRC), .LEVEL_IDX(LEVEL_IDX)) u_pend (
    .clk(clk), .rst_n(rst_n), .src(src_in), .clr(clr), .pend_q(pend_q), .rise(rise)
  );

  assign req_fast = pend_q & en_q & fast_route;
  assign req_norm = pend_q & en_q & ~fast_route;

  intc_arb #(.NSRC(NSRC)) u_arb_fast (
    .req(req_fast), .prio(prio_q), .valid(fast_valid), .win(fast_win)
  );
  intc_arb #(.NSRC(NSRC)) u_arb_norm (
    .req(req_norm), .prio(prio_q), .valid(norm_valid), .win(norm_win)
  );

  assign fast_entry = entry_word(base_q, int'(fast_win), fast_valid);
  assign norm_entry = entry_word(base_q, int'(norm_win), norm_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fiq_q <= 1'b1;
      irq_q <= 1'b1;
    end else begin
      fiq_q <= ~|req_fast;
      irq_q <= ~|req_norm;
    end
  end
  assign fiq_n = fiq_q;
  assign irq_n = irq_q;

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (bus_addr == word_addr(ADR_FAST_PEND, b))
        bus_rdata = (pend_q[b*BANK_W +: BANK_W] & fast_route[b*BANK_W +: BANK_W]);
      if (bus_addr == word_addr(ADR_NORM_PEND, b))
        bus_rdata = (pend_q[b*BANK_W +: BANK_W] & ~fast_route[b*BANK_W +: BANK_W]);
      if (bus_addr == word_addr(ADR_ENABLE, b))
        bus_rdata = en_q[b*BANK_W +: BANK_W];
    end
    for (int r = 0; r < NPREG; r++) begin
      if (bus_addr == word_addr(ADR_PRIO, r)) begin
        for (int k = 0; k < SRC_PER_PREG; k++)
          bus_rdata[4*k +: 4] = {1'b0, prio_q[(r*SRC_PER_PREG+k)*PRIO_W +: PRIO_W]};
      end
    end
    if (bus_addr == ADR_FAST_ENTRY) bus_rdata = fast_entry;
    if (bus_addr == ADR_NORM_ENTRY) bus_rdata = norm_entry;
    if (bus_addr == ADR_CTRL)       bus_rdata = {31'b0, ctrl_q};
    if (bus_addr == ADR_BASE)       bus_rdata = base_q;
  end

  // R11/R6: each output reflects its path one edge later
  p_fiq_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fiq_n == !$past(|req_fast)));
  p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_n == !$past(|req_norm)));
  // R7: a winner is always a live requester on its path
  p_fast_win_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fast_valid |-> req_fast[fast_win]);
  p_norm_win_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
    norm_valid |-> req_norm[norm_win]);
  // R8: no winner only when the path is idle
  p_idle_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!norm_valid |-> (req_norm == '0)) and (!fast_valid |-> (req_fast == '0)));
endmodule

// File: tb/sim_prio_intc.sv
`timescale 1ns/1ps
module sim_prio_intc;
  localparam int NS = 64;
  localparam int LVL = 45;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NS-1:0] src_in = '0;
  logic fiq_n, irq_n;

  prio_intc #(.NSRC(NS), .LEVEL_IDX(LVL)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .fiq_n(fiq_n), .irq_n(irq_n)
  );

  always #2 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  // behavioural model
  logic [NS-1:0] m_pend = '0, m_en = '0, m_prev = '0, cur_src = '0;
  logic [2:0] m_prio [NS];
  logic [31:0] m_base = '0;
  logic m_ctrl = 1'b0;
  logic m_fiq_n = 1'b1, m_irq_n = 1'b1;

  function automatic logic is_fast(input int n);
    return m_prio[n] < 3'd2;
  endfunction

  function automatic logic [31:0] exp_entry(input logic fast);
    int win = -1;
    int best = 8;
    for (int n = 0; n < NS; n++)
      if (m_pend[n] && m_en[n] && (is_fast(n) == fast) && int'(m_prio[n]) < best) begin
        best = int'(m_prio[n]);
        win = n;
      end
    return (win < 0) ? 32'h0 : m_base + 32'((win + 1) * 4);
  endfunction

  function automatic logic [31:0] pend_view(input int bank, input logic fast);
    logic [31:0] v;
    for (int i = 0; i < 32; i++) v[i] = m_pend[bank*32+i] && (is_fast(bank*32+i) == fast);
    return v;
  endfunction

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    logic [31:0] v = '0;
    case (a)
      8'h00: v = pend_view(0, 1'b1);
      8'h04: v = pend_view(1, 1'b1);
      8'h08: v = pend_view(0, 1'b0);
      8'h0C: v = pend_view(1, 1'b0);
      8'h10: v = exp_entry(1'b1);
      8'h14: v = exp_entry(1'b0);
      8'h18: v = m_en[31:0];
      8'h1C: v = m_en[63:32];
      8'h20: v = {31'b0, m_ctrl};
      8'h24: v = m_base;
      default:
        if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
          for (int k = 0; k < 8; k++) v[4*k +: 4] = {1'b0, m_prio[(int'(a) - 48) / 4 * 8 + k]};
    endcase
    return v;
  endfunction

  function automatic logic [7:0] reg_addr(input int i);
    if (i < 10) return 8'(i * 4);
    return 8'(8'h30 + (i - 10) * 4);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    bus_addr = a;
    #0.1;
    chk(tag, bus_rdata, exp_read(a));
  endtask

  task automatic outs(input string tag);
    chk({tag, " fiq_n"}, {31'b0, fiq_n}, {31'b0, m_fiq_n});
    chk({tag, " irq_n"}, {31'b0, irq_n}, {31'b0, m_irq_n});
  endtask

  // one clock: called at a falling edge, returns at the next falling edge
  task automatic step(input logic we, input logic [7:0] a, input logic [31:0] d,
                      input logic [NS-1:0] s);
    logic [NS-1:0] fastv, clrv, rise;
    bus_we = we; bus_addr = a; bus_wdata = d; src_in = s; cur_src = s;
    @(posedge clk);
    for (int n = 0; n < NS; n++) fastv[n] = is_fast(n);
    m_fiq_n = ~|(m_pend & m_en & fastv);
    m_irq_n = ~|(m_pend & m_en & ~fastv);
    clrv = '0;
    if (we) begin
      case (a)
        8'h00: clrv[31:0]  = d & fastv[31:0];
        8'h04: clrv[63:32] = d & fastv[63:32];
        8'h08: clrv[31:0]  = d & ~fastv[31:0];
        8'h0C: clrv[63:32] = d & ~fastv[63:32];
        default: ;
      endcase
    end
    rise = s & ~m_prev;
    m_pend = (m_pend & ~clrv) | rise;
    m_pend[LVL] = s[LVL];
    m_prev = s;
    if (we) begin
      case (a)
        8'h18: m_en[31:0] = d;
        8'h1C: m_en[63:32] = d;
        8'h20: m_ctrl = d[0];
        8'h24: m_base = d;
        default:
          if (a >= 8'h30 && a <= 8'h4C && a[1:0] == 2'b00)
            for (int k = 0; k < 8; k++) m_prio[(int'(a) - 48) / 4 * 8 + k] = d[4*k +: 3];
      endcase
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic idle();
    step(1'b0, 8'h00, 32'h0, cur_src);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog R11: actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [NS-1:0] s;
    for (int n = 0; n < NS; n++) m_prio[n] = 3'd7;
    void'($urandom(32'h5eed_1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // reset state
    outs("R11 reset");
    rd(8'h18, "R4 reset enable0");
    rd(8'h1C, "R4 reset enable1");
    rd(8'h30, "R5 reset prio0");
    rd(8'h4C, "R5 reset prio7");
    rd(8'h24, "R9 reset base");
    rd(8'h20, "R9 reset ctrl");
    rd(8'h10, "R8 reset fast entry");
    rd(8'h14, "R8 reset norm entry");
    chk("R5 reset prio literal", exp_read(8'h34), 32'h7777_7777);

    // R1: edge on source 5 while disabled
    s = '0; s[5] = 1'b1;
    step(1'b0, 8'h00, 32'h0, s);
    rd(8'h08, "R1 normal pending bank0");
    chk("R1 bit5 literal", bus_rdata, 32'h0000_0020);
    idle();
    outs("R4 disabled source silent");
    rd(8'h14, "R4 disabled no entry");
    step(1'b1, 8'h18, 32'h0000_0020, cur_src);
    outs("R11 output one edge behind enable");
    rd(8'h14, "R8 entry source5");
    chk("R8 entry literal", bus_rdata, 32'd24);
    idle();
    outs("R11 irq asserted");

    // R2: zero write, wrong-path write, right-path write
    step(1'b1, 8'h08, 32'h0, cur_src);
    rd(8'h08, "R2 zero write ignored");
    step(1'b1, 8'h00, 32'hFFFF_FFFF, cur_src);
    rd(8'h08, "R2 fast view clear ignores normal source");
    step(1'b1, 8'h08, 32'h0000_0020, cur_src);
    rd(8'h08, "R2 cleared");
    chk("R2 cleared literal", bus_rdata, 32'h0);
    idle();
    outs("R2 irq released");

    // R3: edge and clear together
    s = cur_src; s[5] = 1'b0;
    step(1'b0, 8'h00, 32'h0, s);
    s[5] = 1'b1;
    step(1'b1, 8'h08, 32'h0000_0020, s);
    rd(8'h08, "R3 edge beats clear");
    chk("R3 literal", bus_rdata, 32'h0000_0020);

    // R5/R6: source 40 at priority 0, reserved bit in nibble 1
    step(1'b1, 8'h44, 32'h7777_77F0, cur_src);
    rd(8'h44, "R5 reserved nibble bit reads 0");
    chk("R5 literal", bus_rdata, 32'h7777_7770);
    step(1'b1, 8'h1C, 32'h0000_0100, cur_src);
    s = cur_src; s[40] = 1'b1;
    step(1'b0, 8'h00, 32'h0, s);
    rd(8'h04, "R6 fast pending bank1");
    rd(8'h10, "R6 fast entry source40");
    chk("R6 fast entry literal", bus_rdata, 32'd164);
    idle();
    outs("R6 fiq asserted");

    // R7: tie and override on the normal path
    step(1'b1, 8'h34, 32'h7774_7747, cur_src);
    step(1'b1, 8'h18, 32'h0000_1220, cur_src);
    s = cur_src; s[9] = 1'b1; s[12] = 1'b1;
    step(1'b0, 8'h00, 32'h0, s);
    rd(8'h14, "R7 tie lower index");
    chk("R7 tie literal", bus_rdata, 32'd40);
    step(1'b1, 8'h34, 32'h7773_7747, cur_src);
    rd(8'h14, "R7 smaller value wins");
    chk("R7 override literal", bus_rdata, 32'd52);

    // R9: base and control
    step(1'b1, 8'h24, 32'h0000_1000, cur_src);
    rd(8'h24, "R9 base readback");
    rd(8'h14, "R9 base in entry");
    step(1'b1, 8'h20, 32'hFFFF_FFFF, cur_src);
    rd(8'h20, "R9 ctrl bit0 only");

    // R10: level source
    step(1'b1, 8'h1C, 32'h0000_2100, cur_src);
    s = cur_src; s[LVL] = 1'b1;
    step(1'b0, 8'h00, 32'h0, s);
    rd(8'h0C, "R10 level set");
    step(1'b1, 8'h0C, 32'hFFFF_FFFF, cur_src);
    rd(8'h0C, "R10 level ignores clear");
    s = cur_src; s[LVL] = 1'b0;
    step(1'b0, 8'h00, 32'h0, s);
    rd(8'h0C, "R10 level follows low");

    // R4: disable all, outputs release
    step(1'b1, 8'h18, 32'h0, cur_src);
    step(1'b1, 8'h1C, 32'h0, cur_src);
    outs("R4 disable at once");
    idle();
    outs("R4 outputs released");
    rd(8'h10, "R4 fast entry idle");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [7:0] a;
      logic [31:0] d;
      logic w;
      s = cur_src ^ ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom});
      op = int'($urandom % 10);
      d = $urandom;
      w = 1'b1;
      a = 8'h00;
      case (op)
        0, 1, 2: a = 8'h18 + 8'(4 * ($urandom % 2));
        3, 4:    a = 8'h30 + 8'(4 * ($urandom % 8));
        5, 6:    a = 8'(4 * ($urandom % 4));
        7:       a = 8'h24;
        default: w = 1'b0;
      endcase
      step(w, a, d, s);
      outs("R6 R11 random");
      rd(8'h10, "R7 R8 random fast entry");
      rd(8'h14, "R7 R8 random normal entry");
      rd(reg_addr(int'($urandom % 18)), "R1 R2 R3 R5 random register");
    end

    finish_run();
  end
endmodule